// File: doc/BRIEF.md
# Trigger Line Conditioning Router

This block turns a bank of external input pins into a small set of internal trigger lines that any counter can use as its hardware arm source. Each trigger line first picks one synchronized pin (or nothing) through a source code, then either passes that level straight through or converts a chosen transition into a one-clock pulse. A per-line combiner then applies a programmable two-input truth table to this line's detector output (source A) and the next line's detector output (source B).

A final arm stage picks one of the conditioned lines with a 3-bit selector and, while its enable bit is set, registers it onto the arm output. All configuration is written through a simple write port that chooses a register kind and a line number. The pin bank is assumed to change in step with the clock and passes through a two-flop synchronizer. Line 0 may route any pin. The other lines accept only a low subset of pins.

Top module: `trig_route`

## Requirements
- R1: While `rst` is high and after reset, `trig_out` and `arm_out` are 0, every line's source code is 63 (unrouted), every combiner function is 0000 and the arm stage is disabled.
- R2: A write with `cfg_kind`=0 loads line `cfg_line`'s detector: bits 7..6 are the mode and bits 5..0 the source code. In mode 00 (level), the line's detector output equals the selected pin. With combiner function 1100 the matching `trig_out` bit follows that pin four clocks after it changes.
- R3: Mode 01 (rising), 10 (falling) and 11 (either) produce a single-clock pulse on `trig_out`, four clocks after the matching pin transition, and nothing on a non-matching transition.
- R4: Source code 63 forces the line's source low, and so do codes 40 to 62, whatever the pins do.
- R5: Line 0 may route any pin 0 to 39. Lines 1 to 7 route only pins 0 to 7. Any other code on those lines gives a low source.
- R6: A write with `cfg_kind`=1 loads line `cfg_line`'s combiner: bits 7..4 the function F, bits 3..2 the B type and bits 1..0 the A type. The line output is F[{A,B}], where A is this line's detector output and B is the detector output of line (index+1) mod 8. So 1100 gives A, 1010 gives B, 1000 gives A AND B and 1110 gives A OR B.
- R7: A type code other than 01 feeds a constant 0 to that combiner input in place of the detector output.
- R8: A write with `cfg_kind`=2 loads the arm stage: bits 2..0 select a trigger line and bit 3 enables it. When enabled, `arm_out` equals the selected `trig_out` bit delayed by one clock.
- R9: While the arm enable bit is 0, `arm_out` stays 0 whatever the trigger lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NUM_PINS (40) | External programmable input pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind: 0 detector, 1 combiner, 2 arm |
| cfg_line | input | LINE_W (3) | Target trigger line for kinds 0 and 1 |
| cfg_wdata | input | SEL_W+2 (8) | Configuration write data |
| trig_out | output | NUM_LINES (8) | Conditioned trigger lines |
| arm_out | output | 1 | Hardware arm signal for the counter |

## Verification
The bench builds the block with its defaults: 40 pins, 8 lines, 6-bit source codes and 8 pins allowed on the restricted lines. Lines 0, 3 and 4 are all in use, so the bench reaches the gap between full and restricted routing (pin 20 rejected on line 3 but pin 39 taken on line 0). It also reaches the unrouted and out-of-range codes, and the cross-line B input of the combiner. The arm selector is moved from line 0 to line 3 to cover both the default routing and a non-zero selection.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;

  typedef enum logic [1:0] {
    EM_LEVEL = 2'b00,
    EM_RISE  = 2'b01,
    EM_FALL  = 2'b10,
    EM_BOTH  = 2'b11
  } edge_mode_e;

  // combiner input type that selects the level/edge detector
  localparam logic [1:0] TYPE_DET = 2'b01;

  // register kinds on the configuration port
  localparam logic [1:0] KIND_DET  = 2'd0;
  localparam logic [1:0] KIND_COMB = 2'd1;
  localparam logic [1:0] KIND_ARM  = 2'd2;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/trig_line.sv
module trig_line
  import trig_route_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int SEL_W    = 6,
  parameter int LINE_IDX = 0,
  parameter int LIM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [SEL_W+1:0]    wdata,
  input  logic [NUM_PINS-1:0] pins,
  output logic                det_q
);
  localparam int              PAD      = 1 << SEL_W;
  localparam logic [SEL_W-1:0] OFF_CODE = '1;
  localparam logic [SEL_W:0]  NP       = (SEL_W+1)'(NUM_PINS);
  localparam logic [SEL_W:0]  LP       = (SEL_W+1)'(LIM_PINS);

  logic [SEL_W-1:0] sel_q;
  edge_mode_e       mode_q;
  logic             prev_q;
  logic [PAD-1:0]   padded;
  logic             range_ok;
  logic             lim_ok;
  logic             src;
  logic             det_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= OFF_CODE;
      mode_q <= EM_LEVEL;
    end else if (we) begin
      sel_q  <= wdata[SEL_W-1:0];
      mode_q <= edge_mode_e'(wdata[SEL_W+1:SEL_W]);
    end
  end

  // line 0 routes every pin, the others only the low subset
  generate
    if (LINE_IDX == 0) begin : g_full
      assign lim_ok = 1'b1;
    end else begin : g_limited
      assign lim_ok = ({1'b0, sel_q} < LP);
    end
  endgenerate

  always_comb begin
    padded = '0;
    padded[NUM_PINS-1:0] = pins;
    range_ok = (sel_q != OFF_CODE) && ({1'b0, sel_q} < NP);
    src = range_ok && lim_ok && padded[sel_q];
    unique case (mode_q)
      EM_LEVEL: det_d = src;
      EM_RISE:  det_d = src & ~prev_q;
      EM_FALL:  det_d = ~src & prev_q;
      EM_BOTH:  det_d = src ^ prev_q;
      default:  det_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      prev_q <= src;
      det_q  <= det_d;
    end
  end

  AST_UNROUTED_LOW: assert property (@(posedge clk) disable iff (rst) ((sel_q == OFF_CODE || {1'b0, sel_q} >= NP) && $stable(sel_q)) |=> !det_q); // R4
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst) (mode_q == EM_RISE && det_q) |=> !det_q); // R3

  generate
    if (LINE_IDX != 0) begin : g_lim_chk
      AST_RESTRICTED_LOW: assert property (@(posedge clk) disable iff (rst) ({1'b0, sel_q} >= LP && $stable(sel_q)) |=> !det_q); // R5
    end
  endgenerate
endmodule

// File: rtl/trig_comb.sv
module trig_comb
  import trig_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       a_in,
  input  logic       b_in,
  output logic       trig_q
);
  logic [3:0] func_q;
  logic [1:0] type_a_q;
  logic [1:0] type_b_q;
  logic       a_eff;
  logic       b_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q   <= '0;
      type_a_q <= '0;
      type_b_q <= '0;
    end else if (we) begin
      func_q   <= wdata[7:4];
      type_b_q <= wdata[3:2];
      type_a_q <= wdata[1:0];
    end
  end

  assign a_eff = (type_a_q == TYPE_DET) && a_in;
  assign b_eff = (type_b_q == TYPE_DET) && b_in;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= func_q[{a_eff, b_eff}];
  end

  AST_COMB_PASS_A: assert property (@(posedge clk) disable iff (rst) (func_q == 4'b1100 && type_a_q == TYPE_DET) |=> (trig_q == $past(a_in))); // R6
  AST_TYPES_OFF: assert property (@(posedge clk) disable iff (rst) (type_a_q != TYPE_DET && type_b_q != TYPE_DET) |=> (trig_q == $past(func_q[0]))); // R7
endmodule

// File: rtl/trig_arm.sv
module trig_arm #(
  parameter int NUM_LINES = 8,
  parameter int SEL_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SEL_W:0]       wdata,
  input  logic [NUM_LINES-1:0] lines,
  output logic                 arm_q
);
  localparam int PAD = 1 << SEL_W;

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [PAD-1:0]   padded;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (we) begin
      en_q  <= wdata[SEL_W];
      sel_q <= wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    padded = '0;
    padded[NUM_LINES-1:0] = lines;
  end

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= en_q && padded[sel_q];
  end

  AST_ARM_OFF: assert property (@(posedge clk) disable iff (rst) !en_q |=> !arm_q); // R9
  AST_ARM_FOLLOW: assert property (@(posedge clk) disable iff (rst) en_q |=> (arm_q == $past(padded[sel_q]))); // R8
endmodule

// File: rtl/trig_route.sv
module trig_route
  import trig_route_pkg::*;
#(
  parameter int NUM_PINS  = 40,
  parameter int NUM_LINES = 8,
  parameter int LIM_PINS  = 8,
  parameter int SEL_W     = 6,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int DATA_W   = SEL_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pins_in,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_kind,
  input  logic [LINE_W-1:0]    cfg_line,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [NUM_LINES-1:0] trig_out,
  output logic                 arm_out
);
  logic [NUM_PINS-1:0]  pins_s;
  logic [NUM_LINES-1:0] det;

  trig_sync #(.W(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_in),
    .q   (pins_s)
  );

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      localparam int NXT = (i + 1) % NUM_LINES;
      logic hit;
      assign hit = cfg_we && (cfg_line == LINE_W'(i));

      trig_line #(
        .NUM_PINS (NUM_PINS),
        .SEL_W    (SEL_W),
        .LINE_IDX (i),
        .LIM_PINS (LIM_PINS)
      ) u_det (
        .clk   (clk),
        .rst   (rst),
        .we    (hit && cfg_kind == KIND_DET),
        .wdata (cfg_wdata),
        .pins  (pins_s),
        .det_q (det[i])
      );

      trig_comb u_comb (
        .clk    (clk),
        .rst    (rst),
        .we     (hit && cfg_kind == KIND_COMB),
        .wdata  (cfg_wdata[7:0]),
        .a_in   (det[i]),
        .b_in   (det[NXT]),
        .trig_q (trig_out[i])
      );
    end
  endgenerate

  trig_arm #(
    .NUM_LINES (NUM_LINES),
    .SEL_W     (LINE_W)
  ) u_arm (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we && cfg_kind == KIND_ARM),
    .wdata (cfg_wdata[LINE_W:0]),
    .lines (trig_out),
    .arm_q (arm_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (trig_out == '0 && !arm_out)); // R1
endmodule

// File: tb/sim_trig_route.sv
`timescale 1ns/1ps
module sim_trig_route;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] pins = '0;
  logic        we = 1'b0;
  logic [1:0]  kind = '0;
  logic [2:0]  line = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  trig;
  logic        arm;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [7:0] trig;
    logic       arm;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_route u0 (
    .clk (clk), .rst (rst), .pins_in (pins),
    .cfg_we (we), .cfg_kind (kind), .cfg_line (line), .cfg_wdata (wdata),
    .trig_out (trig), .arm_out (arm)
  );

  // monitor: pop every item whose cycle has come and compare
  always @(negedge clk) begin
    while (sb.size() != 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.due != cyc || trig !== e.trig || arm !== e.arm) begin
        errors++;
        $display("FAIL %s: cycle %0d trig=%h arm=%b expected trig=%h arm=%b", e.tag, cyc, trig, arm, e.trig, e.arm);
      end
    end
  end

  task automatic expect_in(input int d, input logic [7:0] t, input logic a, input string tag);
    exp_t e;
    e.due = cyc + d; e.trig = t; e.arm = a; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] l, input logic [7:0] d);
    kind = k; line = l; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, cycle %0d expected end", cyc);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: quiet during reset
    checks++;
    if (trig !== 8'h00 || arm !== 1'b0) begin
      errors++;
      $display("FAIL R1: trig=%h arm=%b expected trig=00 arm=0", trig, arm);
    end
    rst = 1'b0;
    pins = '1;
    // R1: unrouted lines and zero functions keep everything low
    expect_in(5, 8'h00, 1'b0, "R1");
    expect_in(6, 8'h00, 1'b0, "R1");
    drain();
    pins = '0;
    idle(4);

    // R2 level mode on line 0, pin 37, pass A; arm line 0
    wr(2'd0, 3'd0, {2'b00, 6'd37});
    wr(2'd1, 3'd0, 8'hC5);
    wr(2'd2, 3'd0, 8'h08);
    idle(6);
    pins[37] = 1'b1;
    expect_in(3, 8'h00, 1'b0, "R2");
    expect_in(4, 8'h01, 1'b0, "R2");
    expect_in(5, 8'h01, 1'b1, "R8");
    drain();
    pins[37] = 1'b0;
    expect_in(3, 8'h01, 1'b1, "R2");
    expect_in(4, 8'h00, 1'b1, "R2");
    expect_in(5, 8'h00, 1'b0, "R8");
    drain();

    // R3 rising edge on pin 5
    wr(2'd0, 3'd0, {2'b01, 6'd5});
    idle(6);
    pins[5] = 1'b1;
    expect_in(4, 8'h01, 1'b0, "R3");
    expect_in(5, 8'h00, 1'b1, "R3");
    expect_in(6, 8'h00, 1'b0, "R3");
    drain();
    pins[5] = 1'b0;
    expect_in(4, 8'h00, 1'b0, "R3");
    expect_in(5, 8'h00, 1'b0, "R3");
    drain();

    // R3 falling edge
    wr(2'd0, 3'd0, {2'b10, 6'd5});
    idle(6);
    pins[5] = 1'b1;
    expect_in(4, 8'h00, 1'b0, "R3");
    expect_in(5, 8'h00, 1'b0, "R3");
    drain();
    pins[5] = 1'b0;
    expect_in(4, 8'h01, 1'b0, "R3");
    expect_in(5, 8'h00, 1'b1, "R3");
    drain();

    // R3 either edge
    wr(2'd0, 3'd0, {2'b11, 6'd5});
    idle(6);
    pins[5] = 1'b1;
    expect_in(4, 8'h01, 1'b0, "R3");
    expect_in(5, 8'h00, 1'b1, "R3");
    drain();
    pins[5] = 1'b0;
    expect_in(4, 8'h01, 1'b0, "R3");
    expect_in(5, 8'h00, 1'b1, "R3");
    drain();

    // R4 code 63 and code 45 stay low with every pin high
    wr(2'd0, 3'd0, {2'b00, 6'd63});
    idle(4);
    pins = '1;
    expect_in(4, 8'h00, 1'b0, "R4");
    expect_in(6, 8'h00, 1'b0, "R4");
    drain();
    wr(2'd0, 3'd0, {2'b00, 6'd45});
    expect_in(3, 8'h00, 1'b0, "R4");
    expect_in(6, 8'h00, 1'b0, "R4");
    drain();
    pins = '0;
    idle(4);

    // R5 line 0 reaches pin 39
    wr(2'd0, 3'd0, {2'b00, 6'd39});
    idle(4);
    pins[39] = 1'b1;
    expect_in(4, 8'h01, 1'b0, "R5");
    drain();
    pins[39] = 1'b0;
    wr(2'd0, 3'd0, {2'b00, 6'd63});
    idle(6);

    // R5 line 3 rejects pin 20, accepts pin 2; arm now on line 3
    wr(2'd1, 3'd3, 8'hC5);
    wr(2'd0, 3'd3, {2'b00, 6'd20});
    wr(2'd2, 3'd0, 8'h0B);
    idle(4);
    pins[20] = 1'b1;
    expect_in(4, 8'h00, 1'b0, "R5");
    expect_in(6, 8'h00, 1'b0, "R5");
    drain();
    pins[20] = 1'b0;
    wr(2'd0, 3'd3, {2'b00, 6'd2});
    idle(4);
    pins[2] = 1'b1;
    expect_in(4, 8'h08, 1'b0, "R5");
    expect_in(5, 8'h08, 1'b1, "R8");
    drain();
    pins[2] = 1'b0;

    // R6 combiner on line 3 with B from line 4 (pin 3)
    wr(2'd0, 3'd4, {2'b00, 6'd3});
    wr(2'd1, 3'd3, 8'h85); // AND
    idle(6);
    pins[2] = 1'b1; pins[3] = 1'b0;
    expect_in(5, 8'h00, 1'b0, "R6");
    drain();
    pins[3] = 1'b1;
    expect_in(5, 8'h08, 1'b1, "R6");
    drain();
    wr(2'd1, 3'd3, 8'hE5); // OR
    pins[2] = 1'b0;
    expect_in(5, 8'h08, 1'b1, "R6");
    drain();
    wr(2'd1, 3'd3, 8'hA5); // B only
    pins[2] = 1'b1; pins[3] = 1'b0;
    expect_in(5, 8'h00, 1'b0, "R6");
    drain();
    pins[2] = 1'b0; pins[3] = 1'b1;
    expect_in(5, 8'h08, 1'b1, "R6");
    drain();

    // R7 A type 00 gives a constant 0 to input A
    wr(2'd1, 3'd3, 8'hC4);
    pins[2] = 1'b1; pins[3] = 1'b1;
    expect_in(5, 8'h00, 1'b0, "R7");
    drain();

    // R9 arm disabled while line 3 is high
    wr(2'd1, 3'd3, 8'hC5);
    wr(2'd2, 3'd0, 8'h03);
    expect_in(4, 8'h08, 1'b0, "R9");
    expect_in(6, 8'h08, 1'b0, "R9");
    drain();

    summary();
  end
endmodule